// File: doc/BRIEF.md
# Serial Register Access Port

A synchronous serial slave that gives a host access to a sixteen-entry file of 8-bit registers over three wires: an active-high chip-select, a serial clock and a bidirectional data line. Every frame carries a 4-bit command, then a 4-bit register address, then an 8-bit data byte. A write command stores the byte in the addressed register. A read command arms a readback, and the addressed register is shifted out in the next frame.

The serial inputs are sampled in the block's own clock domain, so the serial clock must run well below the system clock. The readback byte goes out on the data line. When the output-select bits in the configuration register are set, it goes out on the demodulated-data pins instead. At all other times those pins pass the demodulator outputs through unchanged.

Register 0x3 holds the crystal divisor, the nearest integer of the crystal frequency divided by 100 kHz. Its value is presented continuously to the rest of the chip.

Top module: `sreg_port`

## Requirements
- R1: After reset, every register reads 0x00 except register 0x3, which holds DIV_RST (default 0x64). `dio_oe_o` is 0, and `ask_data_o`/`fsk_data_o` follow `ask_demod_i`/`fsk_demod_i`.
- R2: A data bit is taken from `dio_i` on each rising `sclk_i`, sampled in the `clk_i` domain, while `cs_i` is high. Frame bits 15..12 form the command, bits 11..8 the address and bits 7..0 the data, each field sent MSB first.
- R3: Command 4'b0001 writes the data byte to the addressed register when the 16th bit is taken. The new value is visible from the next `clk_i` cycle.
- R4: A frame that ends (`cs_i` falling) after fewer than 16 bits changes no register and arms no readback.
- R5: Bits after the 16th in a frame are ignored. Command codes other than 4'b0001 and 4'b0010 change nothing.
- R6: Command 4'b0010 (data byte zero) captures the addressed register. In the next frame the captured byte is presented MSB first. The byte is valid from frame start, and it advances one bit in the `clk_i` cycle after each taken serial-clock rise. That readback frame is never decoded as a command.
- R7: `dio_oe_o` is high only in a readback frame, and only until 8 bits have been shifted, and only when neither output-select bit is set. At all other times `dio_oe_o` is 0.
- R8: Register 0x0 bit 0 routes the readback onto `ask_data_o`, and bit 1 routes it onto `fsk_data_o`. Both bits may be set together. Outside the readback bits, each of these pins passes its demodulator input through.
- R9: `xtal_div_o` always shows the contents of register 0x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip-select, active high |
| sclk_i | input | 1 | Serial clock |
| dio_i | input | 1 | Data line, pad input |
| dio_o | output | 1 | Data line, pad output value |
| dio_oe_o | output | 1 | Data line output enable |
| ask_demod_i | input | 1 | Amplitude demodulator data |
| fsk_demod_i | input | 1 | Frequency demodulator data |
| ask_data_o | output | 1 | Amplitude data output pin |
| fsk_data_o | output | 1 | Frequency data output pin |
| xtal_div_o | output | 8 | Crystal divisor (register 0x3) |

## Verification
Two functions can act on a demodulated-data pin in the same cycle: passing the demodulator through, and presenting a readback bit. They coincide on the shift of the last readback bit, when the pin switches back to passthrough. To provoke this, the bench toggles the demodulator inputs pseudo-randomly on every clock while routed readbacks run under each setting of the select bits. A behavioural model predicts every pin on every clock, and the bench compares each pin against it. The host also collects the readback bits and compares the assembled byte against the value written earlier.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned CMD_W  = 4;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;

  localparam logic [CMD_W-1:0] CMD_WRITE = 4'b0001;
  localparam logic [CMD_W-1:0] CMD_READ  = 4'b0010;

  typedef enum logic [1:0] {
    RB_IDLE   = 2'd0,
    RB_ARMED  = 2'd1,
    RB_ACTIVE = 2'd2
  } rb_state_e;
endpackage

// File: rtl/sreg_frame_rx.sv
module sreg_frame_rx #(
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               sclk_i,
  input  logic               dio_i,
  output logic               bit_stb_o,
  output logic               cs_rise_o,
  output logic               cs_fall_o,
  output logic               frame_done_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic               sclk_q, cs_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_i;
    end
  end

  assign bit_stb_o = cs_i & sclk_i & ~sclk_q;
  assign cs_rise_o = cs_i & ~cs_q;
  assign cs_fall_o = ~cs_i & cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!cs_i) begin
      cnt_q <= '0;
    end else if (bit_stb_o && (cnt_q < CNT_W'(FRAME_W))) begin
      sh_q  <= {sh_q[FRAME_W-2:0], dio_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // word including the bit being taken this cycle
  assign frame_o      = {sh_q[FRAME_W-2:0], dio_i};
  assign frame_done_o = bit_stb_o && (cnt_q == CNT_W'(FRAME_W - 1));
  assign cnt_o        = cnt_q;
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RST_ADDR = 3,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  localparam int unsigned DEPTH   = 1 << ADDR_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [DATA_W-1:0]            rd_data_o,
  output logic [DEPTH-1:0][DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    localparam logic [DATA_W-1:0] INIT = (g == RST_ADDR) ? RST_VAL : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       regs_o[g] <= INIT;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(g)))     regs_o[g] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_o[rd_addr_i];
endmodule

// File: rtl/sreg_readback.sv
module sreg_readback
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              adv_i,
  input  logic              ask_sel_i,
  input  logic              fsk_sel_i,
  input  logic              ask_demod_i,
  input  logic              fsk_demod_i,
  output logic              dio_o,
  output logic              dio_oe_o,
  output logic              ask_o,
  output logic              fsk_o,
  output rb_state_e         state_o,
  output logic [CNT_W-1:0]  cnt_o
);
  rb_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RB_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RB_IDLE: if (load_i) begin
          state_q <= RB_ARMED;
          sh_q    <= load_data_i;
          cnt_q   <= '0;
        end
        RB_ARMED: if (start_i) state_q <= RB_ACTIVE;
        RB_ACTIVE: begin
          if (stop_i) state_q <= RB_IDLE;
          else if (adv_i && (cnt_q < CNT_W'(DATA_W))) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RB_IDLE;
      endcase
    end
  end

  assign drive    = (state_q == RB_ACTIVE) && (cnt_q < CNT_W'(DATA_W));
  assign dio_o    = sh_q[DATA_W-1];
  assign dio_oe_o = drive && !ask_sel_i && !fsk_sel_i;
  assign ask_o    = (drive && ask_sel_i) ? sh_q[DATA_W-1] : ask_demod_i;
  assign fsk_o    = (drive && fsk_sel_i) ? sh_q[DATA_W-1] : fsk_demod_i;
  assign state_o  = state_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int unsigned CFG_ADDR    = 0,
  parameter int unsigned DIV_ADDR    = 3,
  parameter int unsigned ASK_SEL_BIT = 0,
  parameter int unsigned FSK_SEL_BIT = 1,
  parameter logic [DATA_W-1:0] DIV_RST = 8'h64,
  localparam int unsigned FRAME_W = CMD_W + ADDR_W + DATA_W,
  localparam int unsigned DEPTH   = 1 << ADDR_W,
  localparam int unsigned FCNT_W  = $clog2(FRAME_W + 1),
  localparam int unsigned RCNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              dio_i,
  output logic              dio_o,
  output logic              dio_oe_o,
  input  logic              ask_demod_i,
  input  logic              fsk_demod_i,
  output logic              ask_data_o,
  output logic              fsk_data_o,
  output logic [DATA_W-1:0] xtal_div_o
);
  logic                         bit_stb, cs_rise, cs_fall, frm_done;
  logic [FRAME_W-1:0]           frm_word;
  logic [FCNT_W-1:0]            frm_cnt;
  logic [CMD_W-1:0]             f_cmd;
  logic [ADDR_W-1:0]            f_addr;
  logic [DATA_W-1:0]            f_data, rd_data;
  logic [DEPTH-1:0][DATA_W-1:0] regs;
  logic                         decode, wr_en, rd_en;
  rb_state_e                    rb_state;
  logic [RCNT_W-1:0]            rb_cnt;

  sreg_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i, .rst_ni, .cs_i, .sclk_i, .dio_i,
    .bit_stb_o(bit_stb), .cs_rise_o(cs_rise), .cs_fall_o(cs_fall),
    .frame_done_o(frm_done), .frame_o(frm_word), .cnt_o(frm_cnt)
  );

  assign {f_cmd, f_addr, f_data} = frm_word;
  // readback frames are consumed, never decoded
  assign decode = frm_done && (rb_state == RB_IDLE);
  assign wr_en  = decode && (f_cmd == CMD_WRITE);
  assign rd_en  = decode && (f_cmd == CMD_READ);

  sreg_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_ADDR(DIV_ADDR), .RST_VAL(DIV_RST)
  ) u_rf (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(f_addr), .wr_data_i(f_data),
    .rd_addr_i(f_addr), .rd_data_o(rd_data), .regs_o(regs)
  );

  sreg_readback #(.DATA_W(DATA_W)) u_rb (
    .clk_i, .rst_ni,
    .load_i(rd_en), .load_data_i(rd_data),
    .start_i(cs_rise), .stop_i(cs_fall), .adv_i(bit_stb),
    .ask_sel_i(regs[CFG_ADDR][ASK_SEL_BIT]),
    .fsk_sel_i(regs[CFG_ADDR][FSK_SEL_BIT]),
    .ask_demod_i, .fsk_demod_i,
    .dio_o, .dio_oe_o, .ask_o(ask_data_o), .fsk_o(fsk_data_o),
    .state_o(rb_state), .cnt_o(rb_cnt)
  );

  assign xtal_div_o = regs[DIV_ADDR];
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
  import sreg_pkg::*;
#(
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned DIV_ADDR = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              dio_oe_o,
  input logic [DATA_W-1:0] xtal_div_o,
  input logic              wr_en,
  input logic [ADDR_W-1:0] f_addr,
  input logic [DATA_W-1:0] f_data,
  input logic [$clog2(FRAME_W+1)-1:0] frm_cnt,
  input logic [$clog2(DATA_W+1)-1:0]  rb_cnt,
  input rb_state_e         rb_state
);
  assert_oe_in_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dio_oe_o |-> $past(cs_i));

  assert_no_write_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs_i) |-> $stable(xtal_div_o));

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && f_addr == ADDR_W'(DIV_ADDR)) |=> (xtal_div_o == $past(f_data)));

  assert_frame_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_cnt <= ($clog2(FRAME_W+1))'(FRAME_W));

  assert_rb_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_cnt <= ($clog2(DATA_W+1))'(DATA_W));

  assert_rb_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_state == RB_ACTIVE && !cs_i) |=> (rb_state == RB_IDLE));
endmodule

bind sreg_port sreg_port_chk #(.FRAME_W(FRAME_W), .DIV_ADDR(DIV_ADDR)) u_chk (
  .clk_i, .rst_ni, .cs_i, .dio_oe_o, .xtal_div_o,
  .wr_en, .f_addr, .f_data, .frm_cnt, .rb_cnt, .rb_state
);

// File: tb/test_sreg_port.sv
module test_sreg_port;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cs_i = 1'b0, sclk_i = 1'b0, dio_i = 1'b0;
  logic       ask_demod_i = 1'b0, fsk_demod_i = 1'b0;
  logic       dio_o, dio_oe_o, ask_data_o, fsk_data_o;
  logic [7:0] xtal_div_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0, noise_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sreg_port i_sreg_port (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_reg[16];
  int m_cnt, m_word, m_phase, m_rb, m_rbn;
  bit m_psclk, m_pcs;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_reg[3] = 'h64;
      m_cnt = 0; m_word = 0; m_phase = 0; m_rb = 0; m_rbn = 0;
      m_psclk = 0; m_pcs = 0;
    end else begin
      bit take, crise, cfall, full;
      int ph;
      take  = cs_i && sclk_i && !m_psclk;
      crise = cs_i && !m_pcs;
      cfall = !cs_i && m_pcs;
      full  = 0;
      ph = m_phase;
      if (ph == 1 && crise) m_phase = 2;
      else if (ph == 2) begin
        if (cfall) m_phase = 0;
        else if (take && m_rbn < 8) begin m_rb = (m_rb << 1) & 'hFF; m_rbn++; end
      end
      if (!cs_i) m_cnt = 0;
      else if (take && m_cnt < 16) begin
        m_word = ((m_word << 1) | dio_i) & 'hFFFF;
        m_cnt++;
        full = (m_cnt == 16);
      end
      if (full && ph == 0) begin
        if ((m_word >> 12) == 1) m_reg[(m_word >> 8) & 'hF] = m_word & 'hFF;
        else if ((m_word >> 12) == 2) begin
          m_phase = 1; m_rb = m_reg[(m_word >> 8) & 'hF]; m_rbn = 0;
        end
      end
      m_psclk = sclk_i; m_pcs = cs_i;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit drv, as, fs, b;
      drv = (m_phase == 2) && (m_rbn < 8);
      as = m_reg[0][0]; fs = m_reg[0][1]; b = m_rb[7];
      check(dio_oe_o == (drv && !as && !fs), "R7 dio_oe_o", dio_oe_o, drv && !as && !fs);
      if (dio_oe_o) check(dio_o == b, "R6 dio_o", dio_o, b);
      check(ask_data_o == ((drv && as) ? b : ask_demod_i), "R8 ask_data_o",
            ask_data_o, (drv && as) ? b : ask_demod_i);
      check(fsk_data_o == ((drv && fs) ? b : fsk_demod_i), "R8 fsk_data_o",
            fsk_data_o, (drv && fs) ? b : fsk_demod_i);
      check(xtal_div_o == m_reg[3][7:0], "R9 xtal_div_o", xtal_div_o, m_reg[3]);
    end
  end

  always @(posedge clk_i) begin
    #1;
    if (noise_en) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ask_demod_i = lfsr[0];
      fsk_demod_i = lfsr[5];
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  logic [7:0] cap_dio, cap_ask, cap_fsk;
  bit oe_seen;

  // host frame: nbits from word MSB first; captures readback bits before each rise
  task automatic frame(input logic [31:0] word, input int nbits);
    cap_dio = 0; cap_ask = 0; cap_fsk = 0; oe_seen = 0;
    cs_i = 1; tick(2);
    for (int i = nbits - 1; i >= 0; i--) begin
      sclk_i = 0; dio_i = word[i]; tick(2);
      if (nbits - 1 - i < 8) begin
        cap_dio = {cap_dio[6:0], dio_o};
        cap_ask = {cap_ask[6:0], ask_data_o};
        cap_fsk = {cap_fsk[6:0], fsk_data_o};
      end
      oe_seen |= dio_oe_o;
      sclk_i = 1; tick(2);
    end
    sclk_i = 0; tick(1);
    cs_i = 0; tick(3);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    frame({16'h0, 4'h1, a, d}, 16);
  endtask

  task automatic rd(input logic [3:0] a);
    frame({16'h0, 4'h2, a, 8'h00}, 16);
    frame(32'h0, 16);
  endtask

  initial begin
    tick(3);
    rst_ni = 1; tick(2);
    // R1 reset state
    check(xtal_div_o == 8'h64, "R1 divisor reset", xtal_div_o, 'h64);
    check(!dio_oe_o, "R1 oe reset", dio_oe_o, 0);
    rd(4'h0); check(cap_dio == 8'h00, "R1 cfg reset", cap_dio, 0);

    wr(4'h3, 8'hA5);
    check(xtal_div_o == 8'hA5, "R3 write divisor", xtal_div_o, 'hA5);
    wr(4'h5, 8'h3C);
    rd(4'h5);
    check(cap_dio == 8'h3C, "R6 readback dio", cap_dio, 'h3C);
    check(oe_seen, "R7 oe in readback", oe_seen, 1);

    frame({16'h0, 4'h1, 4'h3, 8'hFF} >> 6, 10);
    check(xtal_div_o == 8'hA5, "R4 short frame", xtal_div_o, 'hA5);
    rd(4'h3); check(cap_dio == 8'hA5, "R4 no arm short", cap_dio, 'hA5);

    frame({16'h0, 4'h7, 4'h3, 8'h00}, 16);
    check(xtal_div_o == 8'hA5, "R5 unknown cmd", xtal_div_o, 'hA5);
    frame({12'h0, 4'h1, 4'h3, 8'h11, 4'hF}, 20);
    check(xtal_div_o == 8'h11, "R5 extra bits", xtal_div_o, 'h11);

    wr(4'h3, 8'h80);
    check(xtal_div_o == 8'h80, "R2 msb first", xtal_div_o, 'h80);
    wr(4'hC, 8'h5A); rd(4'hC);
    check(cap_dio == 8'h5A, "R2 address order", cap_dio, 'h5A);

    // readback frame carrying a write is consumed
    frame({16'h0, 4'h2, 4'h5, 8'h00}, 16);
    frame({16'h0, 4'h1, 4'h3, 8'h00}, 16);
    check(cap_dio == 8'h3C, "R6 readback value", cap_dio, 'h3C);
    check(xtal_div_o == 8'h80, "R6 readback not decoded", xtal_div_o, 'h80);
    frame(32'h0, 16);
    check(!oe_seen, "R7 no drive after readback", oe_seen, 0);

    noise_en = 1;
    wr(4'h0, 8'h01); rd(4'h5);
    check(cap_ask == 8'h3C, "R8 ask route", cap_ask, 'h3C);
    check(!oe_seen, "R7 no oe when routed", oe_seen, 0);
    wr(4'h0, 8'h02); rd(4'h5);
    check(cap_fsk == 8'h3C, "R8 fsk route", cap_fsk, 'h3C);
    wr(4'h0, 8'h03); rd(4'hC);
    check(cap_ask == 8'h5A && cap_fsk == 8'h5A, "R8 both routes", {cap_ask, cap_fsk}, 'h5A5A);
    wr(4'h0, 8'h00); rd(4'h5);
    check(cap_dio == 8'h3C, "R8 back to dio", cap_dio, 'h3C);
    noise_en = 0;
    tick(4);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule